// File: doc/BRIEF.md
# Accumulator Microcomputer Control Sequencer

This block is a small accumulator processor core organised around one shared internal data bus. Its program counter, instruction register, memory address register, accumulator, operand register, flag register and adder all hang off that bus. A sequencer steps each instruction through a fixed list of machine cycles. In each cycle it raises the strobes that pick one bus driver and the registers that capture the bus value.

Instructions and data share one small memory outside the core. The core reads that memory through an address output, an active-low read strobe and a data input. Every instruction begins with a three-cycle fetch. Load, add and jump then run their own execute sequences of different lengths. Every other opcode retires right after the fetch.

The accumulator, program counter, flags, bus-driver selection and an end-of-instruction pulse are outputs, so a program's progress can be followed at the ports.

Top module: `acc_seq_core`

## Requirements
- R1: At most one source drives the internal bus in any cycle. `bus_src` shows the active sources: bit 0 is the program counter, bit 1 the instruction register, bit 2 the memory data input, bit 3 the adder result.
- R2: An instruction is 8 bits. Bits [7:4] hold the opcode (4'h1 load, 4'h2 add, 4'h3 jump) and bits [3:0] hold a memory address.
- R3: Each instruction starts with a three-cycle fetch. The program counter is placed on the address output, the word is read into the instruction register, and the program counter increments, wrapping from 15 to 0.
- R4: Load copies the addressed memory word into the accumulator. It sets the zero flag from that word and leaves carry unchanged. Fetch plus execute takes 6 cycles.
- R5: Add sums the accumulator and the addressed word modulo 256. Carry becomes the carry-out and zero is set when the sum is 0. Add takes 7 cycles in total.
- R6: Jump loads the program counter from the address field and leaves the accumulator and flags unchanged. Jump takes 5 cycles in total.
- R7: Any opcode other than 4'h1, 4'h2 or 4'h3 retires after the 3-cycle fetch. Only the program-counter increment takes effect.
- R8: `mem_rd_n` is low for exactly one cycle per read, and `mem_addr` is held in the following cycle. The core takes the read data in that following cycle.
- R9: A synchronous reset clears the program counter, accumulator, operand register, flags and address register, and restarts the sequencer at the first fetch cycle. In that cycle `mem_rd_n` is high and `bus_src` is 4'b0001.
- R10: `instr_done` is high in exactly the last cycle of every instruction. The instruction's register updates appear after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | AW | Memory address |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_rdata | input | DW | Memory read data, valid the cycle after the strobe |
| acc_q | output | DW | Accumulator |
| pc_q | output | AW | Program counter |
| carry_q | output | 1 | Carry flag |
| zero_q | output | 1 | Zero flag |
| bus_src | output | 4 | One bit per active bus driver |
| instr_done | output | 1 | Final cycle of the current instruction |

## Verification
The hardest case to reach from the ports is an add whose carry-out appears together with a zero result. The next test is that a later load leaves that carry untouched while it rewrites zero. A directed program therefore loads 0xF0, adds 0x10, and then loads 0x00 and 0x03. A further add clears the carry again. A second program places a jump at address 8 that targets address 15 and then adds there, so the program counter has to wrap from 15 to 0. A reset raised in the middle of a fetch read checks that the sequencer restarts cleanly.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  localparam int OPW  = 4;
  localparam int NSRC = 4;
  localparam int SRC_PC  = 0;
  localparam int SRC_IR  = 1;
  localparam int SRC_MEM = 2;
  localparam int SRC_ALU = 3;

  localparam logic [OPW-1:0] OPC_LOAD = 4'h1;
  localparam logic [OPW-1:0] OPC_ADD  = 4'h2;
  localparam logic [OPW-1:0] OPC_JUMP = 4'h3;

  typedef enum logic [2:0] {
    ST_FADDR, ST_FREAD, ST_FLATCH, ST_EX1, ST_EX2, ST_EX3, ST_EX4
  } step_e;

  typedef enum logic {ALU_PASS_B = 1'b0, ALU_ADD = 1'b1} alu_op_e;

  typedef struct packed {
    logic    pc_rd;
    logic    pc_wr;
    logic    pc_inc;
    logic    ir_rd;
    logic    ir_wr;
    logic    mar_wr;
    logic    mem_rd;
    logic    mem_drv;
    logic    acc_wr;
    logic    b_wr;
    logic    alu_rd;
    alu_op_e alu_op;
    logic    flg_cz_wr;
    logic    flg_z_wr;
    logic    done;
  } strobe_t;

  function automatic logic op_known(input logic [OPW-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_ADD) || (op == OPC_JUMP);
  endfunction
endpackage

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   res,
  output logic            cout
);
  function automatic logic [DW:0] alu_eval(input alu_op_e f,
                                           input logic [DW-1:0] x,
                                           input logic [DW-1:0] y);
    case (f)
      ALU_ADD: return {1'b0, x} + {1'b0, y};
      default: return {1'b0, y};
    endcase
  endfunction

  assign {cout, res} = alu_eval(op, a, b);
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] ir_op,
  input  logic [OPW-1:0] bus_op,
  output strobe_t        stb
);
  step_e step_q, step_d;

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_FADDR;
    else     step_q <= step_d;
  end

  // next machine cycle: sequence length depends on the opcode
  always_comb begin
    step_d = ST_FADDR;
    case (step_q)
      ST_FADDR:  step_d = ST_FREAD;
      ST_FREAD:  step_d = ST_FLATCH;
      ST_FLATCH: step_d = op_known(bus_op) ? ST_EX1 : ST_FADDR;
      ST_EX1:    step_d = ST_EX2;
      ST_EX2:    step_d = (ir_op == OPC_JUMP) ? ST_FADDR : ST_EX3;
      ST_EX3:    step_d = (ir_op == OPC_LOAD) ? ST_FADDR : ST_EX4;
      default:   step_d = ST_FADDR;
    endcase
  end

  // strobes for the current machine cycle
  always_comb begin
    stb = '0;
    case (step_q)
      ST_FADDR: begin
        stb.pc_rd  = 1'b1;
        stb.mar_wr = 1'b1;
      end
      ST_FREAD: stb.mem_rd = 1'b1;
      ST_FLATCH: begin
        stb.mem_drv = 1'b1;
        stb.ir_wr   = 1'b1;
        stb.pc_inc  = 1'b1;
        stb.done    = !op_known(bus_op);
      end
      ST_EX1: begin
        stb.ir_rd  = 1'b1;
        stb.mar_wr = (ir_op != OPC_JUMP);
      end
      ST_EX2: begin
        if (ir_op == OPC_JUMP) begin
          stb.ir_rd = 1'b1;
          stb.pc_wr = 1'b1;
          stb.done  = 1'b1;
        end else begin
          stb.mem_rd = 1'b1;
        end
      end
      ST_EX3: begin
        stb.mem_drv = 1'b1;
        if (ir_op == OPC_LOAD) begin
          stb.acc_wr   = 1'b1;
          stb.flg_z_wr = 1'b1;
          stb.done     = 1'b1;
        end else begin
          stb.b_wr = 1'b1;
        end
      end
      ST_EX4: begin
        stb.alu_rd    = 1'b1;
        stb.alu_op    = ALU_ADD;
        stb.acc_wr    = 1'b1;
        stb.flg_cz_wr = 1'b1;
        stb.done      = 1'b1;
      end
      default: stb = '0;
    endcase
  end
endmodule

// File: rtl/acc_seq_datapath.sv
module acc_seq_datapath
  import acc_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  strobe_t         stb,
  input  logic [DW-1:0]   mem_rdata,
  input  logic [DW-1:0]   alu_res,
  input  logic            alu_cout,
  output logic [DW-1:0]   bus,
  output logic [NSRC-1:0] src_sel,
  output logic [DW-1:0]   ir_q,
  output logic [AW-1:0]   pc_q,
  output logic [AW-1:0]   mar_q,
  output logic [DW-1:0]   acc_q,
  output logic [DW-1:0]   b_q,
  output logic            carry_q,
  output logic            zero_q
);
  localparam int PADW = DW - AW;

  logic [DW-1:0] pc_ext;
  assign pc_ext = {{PADW{1'b0}}, pc_q};

  always_comb begin
    src_sel          = '0;
    src_sel[SRC_PC]  = stb.pc_rd;
    src_sel[SRC_IR]  = stb.ir_rd;
    src_sel[SRC_MEM] = stb.mem_drv;
    src_sel[SRC_ALU] = stb.alu_rd;
  end

  assign bus = ({DW{stb.pc_rd}}   & pc_ext)
             | ({DW{stb.ir_rd}}   & ir_q)
             | ({DW{stb.mem_drv}} & mem_rdata)
             | ({DW{stb.alu_rd}}  & alu_res);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q    <= '0;
      pc_q    <= '0;
      mar_q   <= '0;
      acc_q   <= '0;
      b_q     <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (stb.ir_wr)  ir_q  <= bus;
      if (stb.mar_wr) mar_q <= bus[AW-1:0];
      if (stb.pc_wr)       pc_q <= bus[AW-1:0];
      else if (stb.pc_inc) pc_q <= pc_q + 1'b1;
      if (stb.acc_wr) acc_q <= bus;
      if (stb.b_wr)   b_q   <= bus;
      if (stb.flg_cz_wr) begin
        carry_q <= alu_cout;
        zero_q  <= (bus == '0);
      end else if (stb.flg_z_wr) begin
        zero_q  <= (bus == '0);
      end
    end
  end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd_n,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   acc_q,
  output logic [AW-1:0]   pc_q,
  output logic            carry_q,
  output logic            zero_q,
  output logic [NSRC-1:0] bus_src,
  output logic            instr_done
);
  strobe_t       stb;
  logic [DW-1:0] bus;
  logic [DW-1:0] ir_q;
  logic [DW-1:0] b_q;
  logic [DW-1:0] alu_res;
  logic          alu_cout;

  // named events for the bound checker
  logic          ev_ir_wr;
  logic          ev_pc_wr;
  logic          ev_add_wb;
  logic          ev_z_only;
  logic [AW-1:0] ir_addr;

  acc_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .ir_op  (ir_q[DW-1 -: OPW]),
    .bus_op (bus[DW-1 -: OPW]),
    .stb    (stb)
  );

  acc_seq_alu #(.DW(DW)) u_alu (
    .op   (stb.alu_op),
    .a    (acc_q),
    .b    (b_q),
    .res  (alu_res),
    .cout (alu_cout)
  );

  acc_seq_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .mem_rdata (mem_rdata),
    .alu_res   (alu_res),
    .alu_cout  (alu_cout),
    .bus       (bus),
    .src_sel   (bus_src),
    .ir_q      (ir_q),
    .pc_q      (pc_q),
    .mar_q     (mem_addr),
    .acc_q     (acc_q),
    .b_q       (b_q),
    .carry_q   (carry_q),
    .zero_q    (zero_q)
  );

  assign mem_rd_n   = !stb.mem_rd;
  assign instr_done = stb.done;

  assign ev_ir_wr  = stb.ir_wr;
  assign ev_pc_wr  = stb.pc_wr;
  assign ev_add_wb = stb.acc_wr & stb.alu_rd;
  assign ev_z_only = stb.flg_z_wr;
  assign ir_addr   = ir_q[AW-1:0];
endmodule

// File: rtl/acc_seq_core_chk.sv
module acc_seq_core_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    bus_src,
  input logic          mem_rd_n,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] pc_q,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] b_q,
  input logic          carry_q,
  input logic          zero_q,
  input logic          ev_ir_wr,
  input logic          ev_pc_wr,
  input logic          ev_add_wb,
  input logic          ev_z_only,
  input logic [AW-1:0] ir_addr,
  input logic          instr_done
);
  a_r1_single_source: assert property (@(posedge clk) disable iff (rst)
    $countones(bus_src) <= 1);

  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    ev_ir_wr |=> pc_q == AW'($past(pc_q) + 1'b1));

  a_r4_load_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    ev_z_only |=> carry_q == $past(carry_q));

  a_r5_add_result: assert property (@(posedge clk) disable iff (rst)
    ev_add_wb |=> {carry_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(b_q)}));

  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    ev_pc_wr |=> pc_q == $past(ir_addr));

  a_r8_rd_single: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |=> mem_rd_n);

  a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |=> $stable(mem_addr));

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && acc_q == '0 && !carry_q && !zero_q && mem_rd_n));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> !instr_done);
endmodule

bind acc_seq_core acc_seq_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_src    (bus_src),
  .mem_rd_n   (mem_rd_n),
  .mem_addr   (mem_addr),
  .pc_q       (pc_q),
  .acc_q      (acc_q),
  .b_q        (b_q),
  .carry_q    (carry_q),
  .zero_q     (zero_q),
  .ev_ir_wr   (ev_ir_wr),
  .ev_pc_wr   (ev_pc_wr),
  .ev_add_wb  (ev_add_wb),
  .ev_z_only  (ev_z_only),
  .ir_addr    (ir_addr),
  .instr_done (instr_done)
);

// File: tb/tb_acc_seq_core.sv
module tb_acc_seq_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] mem_addr;
  logic       mem_rd_n;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] acc_q;
  logic [3:0] pc_q;
  logic       carry_q, zero_q;
  logic [3:0] bus_src;
  logic       instr_done;

  logic [7:0] mem [0:15];

  int checks = 0;
  int failures = 0;
  int conflicts = 0;
  int rd_viol = 0;
  int rd_count = 0;
  bit prev_rd_low = 1'b0;
  logic [3:0] prev_addr = 4'h0;

  always #5 clk = ~clk;

  acc_seq_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n),
    .mem_rdata(mem_rdata), .acc_q(acc_q), .pc_q(pc_q), .carry_q(carry_q),
    .zero_q(zero_q), .bus_src(bus_src), .instr_done(instr_done)
  );

  // memory: captures on the edge that ends the read cycle, presents next cycle
  always_ff @(posedge clk) begin
    if (!mem_rd_n) mem_rdata <= mem[mem_addr];
  end

  // bus and read-protocol monitors (R1, R8)
  always @(negedge clk) begin
    if (rst) begin
      prev_rd_low = 1'b0;
    end else begin
      if ($countones(bus_src) > 1) conflicts++;
      if (prev_rd_low && !mem_rd_n) rd_viol++;
      if (prev_rd_low && mem_addr != prev_addr) rd_viol++;
      if (!mem_rd_n) rd_count++;
      prev_rd_low = !mem_rd_n;
      prev_addr   = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // starts at the negedge of an instruction's first cycle, ends at the next one
  task automatic run_instr(input string req, input int exp_cyc,
                           input logic [7:0] eacc, input logic [3:0] epc,
                           input bit ec, input bit ez);
    int n = 0;
    bit seen = 1'b0;
    while (n < 20 && !seen) begin
      n++;
      if (instr_done) seen = 1'b1;
      else @(negedge clk);
    end
    @(negedge clk);
    chk(n == exp_cyc, req, "cycles", n, exp_cyc);
    chk(acc_q == eacc, req, "acc", acc_q, eacc);
    chk(pc_q == epc, req, "pc", pc_q, epc);
    chk(carry_q == ec, req, "carry", carry_q, ec);
    chk(zero_q == ez, req, "zero", zero_q, ez);
  endtask

  task automatic t_reset_state();
    clear_mem();
    do_reset();
    chk(pc_q == 4'h0 && acc_q == 8'h00, "R9", "pc/acc after reset", {pc_q, acc_q}, 0);
    chk(!carry_q && !zero_q, "R9", "flags after reset", {carry_q, zero_q}, 0);
    chk(mem_rd_n == 1'b1, "R9", "rd_n after reset", mem_rd_n, 1);
    chk(bus_src == 4'b0001, "R9", "bus_src in first fetch cycle", bus_src, 4'b0001);
  endtask

  // R2 R3 R4 R5 R6 R10: load, add, jump back, repeat
  task automatic t_main_loop();
    clear_mem();
    mem[0] = 8'h1A; mem[1] = 8'h2B; mem[2] = 8'h30;
    mem[10] = 8'h05; mem[11] = 8'h07;
    do_reset();
    run_instr("R4", 6, 8'h05, 4'h1, 1'b0, 1'b0);
    run_instr("R5", 7, 8'h0C, 4'h2, 1'b0, 1'b0);
    run_instr("R6", 5, 8'h0C, 4'h0, 1'b0, 1'b0);
    run_instr("R4", 6, 8'h05, 4'h1, 1'b0, 1'b0);
    run_instr("R5", 7, 8'h0C, 4'h2, 1'b0, 1'b0);
  endtask

  // R5 carry with zero, R4 load keeps carry
  task automatic t_flags();
    clear_mem();
    mem[0] = 8'h1C; mem[1] = 8'h2D; mem[2] = 8'h1E; mem[3] = 8'h1F; mem[4] = 8'h2C;
    mem[12] = 8'hF0; mem[13] = 8'h10; mem[14] = 8'h00; mem[15] = 8'h03;
    do_reset();
    run_instr("R4", 6, 8'hF0, 4'h1, 1'b0, 1'b0);
    run_instr("R5", 7, 8'h00, 4'h2, 1'b1, 1'b1);
    run_instr("R4", 6, 8'h00, 4'h3, 1'b1, 1'b1);
    run_instr("R4", 6, 8'h03, 4'h4, 1'b1, 1'b0);
    run_instr("R5", 7, 8'hF3, 4'h5, 1'b0, 1'b0);
  endtask

  // R7 unknown opcodes, R6 forward jump, R3 pc wrap 15 -> 0
  task automatic t_nop_jump();
    clear_mem();
    mem[0] = 8'h00; mem[1] = 8'hF5; mem[2] = 8'h37; mem[3] = 8'h1B;
    mem[7] = 8'h1A; mem[8] = 8'h3F; mem[10] = 8'h77; mem[11] = 8'h55;
    mem[15] = 8'h2A;
    do_reset();
    run_instr("R7", 3, 8'h00, 4'h1, 1'b0, 1'b0);
    run_instr("R7", 3, 8'h00, 4'h2, 1'b0, 1'b0);
    run_instr("R6", 5, 8'h00, 4'h7, 1'b0, 1'b0);
    run_instr("R4", 6, 8'h77, 4'h8, 1'b0, 1'b0);
    run_instr("R6", 5, 8'h77, 4'hF, 1'b0, 1'b0);
    run_instr("R3", 7, 8'hEE, 4'h0, 1'b0, 1'b0);
  endtask

  // R9 reset during a fetch read, then restart from address 0
  task automatic t_mid_reset();
    clear_mem();
    mem[0] = 8'h1A; mem[1] = 8'h2B; mem[2] = 8'h30;
    mem[10] = 8'h05; mem[11] = 8'hFF;
    do_reset();
    run_instr("R4", 6, 8'h05, 4'h1, 1'b0, 1'b0);
    run_instr("R5", 7, 8'h04, 4'h2, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(pc_q == 4'h0 && acc_q == 8'h00, "R9", "pc/acc after mid reset", {pc_q, acc_q}, 0);
    chk(!carry_q && !zero_q, "R9", "flags after mid reset", {carry_q, zero_q}, 0);
    chk(bus_src == 4'b0001 && mem_rd_n, "R9", "restart in fetch", {bus_src, mem_rd_n}, 5'b00011);
    run_instr("R9", 6, 8'h05, 4'h1, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_main_loop();
    t_flags();
    t_nop_jump();
    t_mid_reset();
    chk(conflicts == 0, "R1", "cycles with several bus drivers", conflicts, 0);
    chk(rd_viol == 0, "R8", "read strobe width / address hold", rd_viol, 0);
    chk(rd_count > 0, "R8", "reads observed", rd_count, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule